// File: doc/BRIEF.md
# Address Table Aging Controller

This block decides when a learned-address table ages its entries. In steady operation it emits a single-cycle age tick once per long interval, measured in timebase strobes (the default constants assume one strobe per microsecond and give a 200 second interval). The table logic outside this block acts on each tick; the storage and per-entry age bits are not part of it.

Each of the three ports reports link status through an asynchronous input. The block synchronizes each input and treats a drop from link to no link as a link-loss event. Any link-loss event raises a one-cycle flush pulse, which tells the table to discard every address. If the fast-aging enable input is high when the loss is seen, the controller also runs one accelerated aging cycle. This cycle is a short burst of ticks with a small spacing, finishing well under 800 microseconds at the default constants. After the burst it returns to the slow interval. An age-active output is high for as long as the accelerated cycle lasts.

Top module: `addr_age_ctrl`

## Requirements
- R1: While reset is low, and on the first sampled cycle after it, age_tick_o, flush_all_o and age_active_o are all 0.
- R2: In slow mode age_tick_o pulses for one cycle after every NORM_STROBES strobes. The first pulse follows the NORM_STROBES-th strobe after reset and appears the cycle after that strobe.
- R3: A port's link-loss event is the falling edge of link_up_i[p] seen through a two-flop synchronizer. A rising edge or a steady level produces no event and no flush.
- R4: Every link-loss event gives a one-cycle flush_all_o pulse three clock edges after the input changes, whatever the enable. Drops on several ports in the same cycle give a single pulse.
- R5: A link-loss event seen in slow mode while fast_age_en_i is 1 raises age_active_o in the same cycle as the flush pulse. It then issues FAST_TICKS ticks spaced FAST_GAP strobes apart, the first FAST_GAP strobes after entry.
- R6: age_active_o falls in the same cycle as the last fast tick. The next tick comes NORM_STROBES strobes later.
- R7: With fast_age_en_i at 0, a link-loss event flushes but leaves age_active_o at 0 and does not move the slow tick schedule.
- R8: A link-loss event during an accelerated cycle still flushes but neither restarts nor extends that cycle.
- R9: When a flush and a tick are due in the same cycle, only the flush appears. In slow mode the interval restarts from that cycle. With the enable set, the accelerated cycle starts instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_up_i | input | NUM_PORTS | Per-port link status, 1 = link, asynchronous |
| fast_age_en_i | input | 1 | Fast aging enable, 1 = run an accelerated cycle on link loss |
| tb_strobe_i | input | 1 | Timebase strobe, one clock wide |
| age_tick_o | output | 1 | One-cycle age tick for the address table |
| age_active_o | output | 1 | High during an accelerated aging cycle |
| flush_all_o | output | 1 | One-cycle request to discard all addresses |

## Verification
A wrong count in the interval counter shows up as a tick that arrives early or late. That error is visible at the first tick after reset, or at the first tick after a mode change, so the bench pins each tick to an exact cycle. A scheduler stuck in the wrong mode shows at once as age_active_o failing to rise with the flush, or as a missing fall at the last fast tick. A lost or doubled edge in the synchronizer path appears three cycles after the link input moves, as a missing, extra or shifted flush pulse.

// File: rtl/addr_age_pkg.sv
// Package: shared types for the address aging controller.
// Assumes: nothing beyond standard SystemVerilog.
package addr_age_pkg;

    // Aging schedule mode: long interval or accelerated burst.
    typedef enum logic [0:0] {
        MODE_SLOW = 1'b0,
        MODE_FAST = 1'b1
    } age_mode_e;

endpackage

// File: rtl/age_link_edge.sv
// Module: age_link_edge
// Synchronizes each port's asynchronous link status through two flops and
// flags the cycle in which the synchronized level falls from 1 to 0.
// Assumes: link inputs are slow level signals; the reset state of 0 means a
// port that is up at reset produces only a rising edge, never a false event.
module age_link_edge #(
    parameter int unsigned NUM_PORTS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] link_up_i,
    output logic [NUM_PORTS-1:0] link_fall_o
);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic meta_q;
        logic sync_q;
        logic prev_q;

        // Two-flop synchronizer plus one stage of history for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= link_up_i[p];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        // Falling edge of the synchronized level.
        assign link_fall_o[p] = prev_q & ~sync_q;

        AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            link_fall_o[p] |=> !link_fall_o[p]); // R3

        AST_FALL_FROM_LOW_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
            link_fall_o[p] |-> $past(!link_up_i[p], 2)); // R3
    end

endmodule

// File: rtl/age_interval_ctr.sv
// Module: age_interval_ctr
// Down-counter of timebase strobes shared by the slow and fast schedules.
// It signals expiry on the strobe that finds it at zero. A load
// overrides counting in the same cycle.
// Assumes: the owner reloads it on every expiry; without a load it holds at 0.
module age_interval_ctr #(
    parameter int unsigned CW        = 8,
    parameter int unsigned RESET_VAL = 0,
    parameter int unsigned MAX_VAL   = 255
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_i,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          expire_o
);

    logic [CW-1:0] cnt_q;

    // Load has priority; otherwise count strobes down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CW'(RESET_VAL);
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (strobe_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Expiry is the strobe that arrives with nothing left to count.
    assign expire_o = strobe_i && (cnt_q == '0);

    AST_CNT_WITHIN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAX_VAL)); // R2

    AST_CNT_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !strobe_i) |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/age_sched_fsm.sv
// Module: age_sched_fsm
// Chooses between the slow interval and the accelerated burst. It drives
// the reload of the interval counter and registers the tick and flush
// pulses, with flush winning over a tick due in the same cycle.
// Assumes: link_fall_i is already synchronized and one cycle per event.
module age_sched_fsm
    import addr_age_pkg::*;
#(
    parameter int unsigned NUM_PORTS    = 3,
    parameter int unsigned CW           = 8,
    parameter int unsigned NORM_STROBES = 200,
    parameter int unsigned FAST_GAP     = 10,
    parameter int unsigned FAST_TICKS   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fast_age_en_i,
    input  logic                 tb_strobe_i,
    input  logic [NUM_PORTS-1:0] link_fall_i,
    input  logic                 expire_i,
    output logic                 load_o,
    output logic [CW-1:0]        load_val_o,
    output logic                 age_tick_o,
    output logic                 age_active_o,
    output logic                 flush_all_o
);

    localparam int unsigned LW       = $clog2(FAST_TICKS + 1);
    localparam logic [CW-1:0] SLOW_RELOAD = CW'(NORM_STROBES - 1);
    localparam logic [CW-1:0] FAST_RELOAD = CW'(FAST_GAP - 1);

    age_mode_e     mode_q, mode_n;
    logic [LW-1:0] left_q, left_n;
    logic          tick_due;
    logic          any_fall;

    assign any_fall = |link_fall_i;

    // Next-state, counter reload and tick decision for the current mode.
    always_comb begin
        mode_n     = mode_q;
        left_n     = left_q;
        load_o     = 1'b0;
        load_val_o = SLOW_RELOAD;
        tick_due   = 1'b0;
        case (mode_q)
            MODE_SLOW: begin
                if (any_fall && fast_age_en_i) begin
                    mode_n     = MODE_FAST;
                    left_n     = LW'(FAST_TICKS - 1);
                    load_o     = 1'b1;
                    load_val_o = FAST_RELOAD;
                end else if (expire_i) begin
                    tick_due   = 1'b1;
                    load_o     = 1'b1;
                    load_val_o = SLOW_RELOAD;
                end
            end
            MODE_FAST: begin
                if (expire_i) begin
                    tick_due = 1'b1;
                    load_o   = 1'b1;
                    if (left_q == '0) begin
                        mode_n     = MODE_SLOW;
                        load_val_o = SLOW_RELOAD;
                    end else begin
                        left_n     = left_q - 1'b1;
                        load_val_o = FAST_RELOAD;
                    end
                end
            end
            default: mode_n = MODE_SLOW;
        endcase
    end

    // State and registered output pulses; flush suppresses a coincident tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= MODE_SLOW;
            left_q      <= '0;
            age_tick_o  <= 1'b0;
            flush_all_o <= 1'b0;
        end else begin
            mode_q      <= mode_n;
            left_q      <= left_n;
            age_tick_o  <= tick_due & ~any_fall;
            flush_all_o <= any_fall;
        end
    end

    assign age_active_o = (mode_q == MODE_FAST);

    AST_TICK_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        age_tick_o |-> $past(tb_strobe_i)); // R2

    AST_FLUSH_OVER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all_o |-> !age_tick_o); // R9

    AST_FAST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(age_active_o) |-> (flush_all_o && $past(fast_age_en_i))); // R5

    AST_FAST_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(age_active_o) |-> $past(expire_i)); // R6

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (age_active_o && !expire_i) |=> $stable(left_q)); // R8

endmodule

// File: rtl/addr_age_ctrl.sv
// Module: addr_age_ctrl (top)
// Aging schedule for a learned-address table: slow periodic ticks, one
// accelerated burst on link loss when enabled, and a flush on any unplug.
// Assumes: tb_strobe_i is a one-cycle strobe at a fixed rate (default
// constants take one strobe per microsecond); reset is synchronous.
module addr_age_ctrl #(
    parameter int unsigned NUM_PORTS    = 3,
    parameter int unsigned NORM_STROBES = 200_000_000,
    parameter int unsigned FAST_GAP     = 100,
    parameter int unsigned FAST_TICKS   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] link_up_i,
    input  logic                 fast_age_en_i,
    input  logic                 tb_strobe_i,
    output logic                 age_tick_o,
    output logic                 age_active_o,
    output logic                 flush_all_o
);

    localparam int unsigned LONGEST = (NORM_STROBES > FAST_GAP) ? NORM_STROBES : FAST_GAP;
    localparam int unsigned CW      = $clog2(LONGEST + 1);

    logic [NUM_PORTS-1:0] link_fall;
    logic                 expire;
    logic                 ctr_load;
    logic [CW-1:0]        ctr_load_val;

    age_link_edge #(
        .NUM_PORTS (NUM_PORTS)
    ) u_link_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .link_up_i   (link_up_i),
        .link_fall_o (link_fall)
    );

    age_interval_ctr #(
        .CW        (CW),
        .RESET_VAL (NORM_STROBES - 1),
        .MAX_VAL   (LONGEST - 1)
    ) u_interval (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_i   (tb_strobe_i),
        .load_i     (ctr_load),
        .load_val_i (ctr_load_val),
        .expire_o   (expire)
    );

    age_sched_fsm #(
        .NUM_PORTS    (NUM_PORTS),
        .CW           (CW),
        .NORM_STROBES (NORM_STROBES),
        .FAST_GAP     (FAST_GAP),
        .FAST_TICKS   (FAST_TICKS)
    ) u_sched (
        .clk           (clk),
        .rst_n         (rst_n),
        .fast_age_en_i (fast_age_en_i),
        .tb_strobe_i   (tb_strobe_i),
        .link_fall_i   (link_fall),
        .expire_i      (expire),
        .load_o        (ctr_load),
        .load_val_o    (ctr_load_val),
        .age_tick_o    (age_tick_o),
        .age_active_o  (age_active_o),
        .flush_all_o   (flush_all_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!age_tick_o && !flush_all_o && !age_active_o)); // R1

endmodule

// File: tb/addr_age_ctrl_bench.sv
`timescale 1ns/1ps
module addr_age_ctrl_bench;

    localparam int NORM = 40;
    localparam int GAP  = 3;
    localparam int FT   = 2;

    // Vector: {drop mask[2:0], enable, expected flushes[1:0], expected fast ticks[1:0], active seen}
    localparam logic [8:0] VEC [0:5] = '{
        {3'b001, 1'b1, 2'd1, 2'd2, 1'b1},
        {3'b010, 1'b0, 2'd1, 2'd0, 1'b0},
        {3'b100, 1'b1, 2'd1, 2'd2, 1'b1},
        {3'b101, 1'b1, 2'd1, 2'd2, 1'b1},
        {3'b000, 1'b1, 2'd0, 2'd0, 1'b0},
        {3'b111, 1'b0, 2'd1, 2'd0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  link_up = 3'b111;
    logic        fast_en = 1'b0;
    logic [31:0] cyc;
    logic        strobe;
    logic        tick, active, flush;

    int checks = 0, failures = 0, wd = 0;
    int n_tick, n_flush, rise_at, fall_at, flush_at;
    int tick_at [0:3];
    logic prev_act;

    always #2 clk = ~clk;

    // Strobe on every second clock, aligned to reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end
    assign strobe = cyc[0];

    addr_age_ctrl #(
        .NUM_PORTS(3), .NORM_STROBES(NORM), .FAST_GAP(GAP), .FAST_TICKS(FT)
    ) u_addr_age_ctrl (
        .clk(clk), .rst_n(rst_n), .link_up_i(link_up), .fast_age_en_i(fast_en),
        .tb_strobe_i(strobe), .age_tick_o(tick), .age_active_o(active),
        .flush_all_o(flush)
    );

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            failures++;
            $display("FAIL watchdog (all requirements) actual=%0d expected<100000", wd);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        n_tick = 0; n_flush = 0; rise_at = -1; fall_at = -1; flush_at = -1;
        prev_act = 1'b0;
        for (int i = 0; i < 4; i++) tick_at[i] = -1;
    endtask

    task automatic run_until(input int t);
        while (int'(cyc) < t) begin
            @(negedge clk);
            if (tick) begin
                if (n_tick < 4) tick_at[n_tick] = int'(cyc);
                n_tick++;
            end
            if (flush) begin
                flush_at = int'(cyc);
                n_flush++;
            end
            if (active && !prev_act) rise_at = int'(cyc);
            if (!active && prev_act) fall_at = int'(cyc);
            prev_act = active;
        end
    endtask

    task automatic do_reset(input logic en);
        @(negedge clk);
        rst_n = 1'b0; link_up = 3'b111; fast_en = en;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        clear_mon();
    endtask

    initial begin
        // R1: outputs quiet while in reset even with link activity.
        repeat (2) @(negedge clk);
        link_up = 3'b000; fast_en = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 tick in reset", int'(tick), 0);
        chk("R1 flush in reset", int'(flush), 0);
        chk("R1 active in reset", int'(active), 0);

        // Vector table: drop pattern vs enable, counted over a window before any slow tick.
        for (int v = 0; v < 6; v++) begin
            do_reset(VEC[v][5]);
            run_until(10);
            link_up = ~VEC[v][8:6];
            run_until(60);
            chk($sformatf("R4 vec%0d flush count", v), n_flush, int'(VEC[v][4:3]));
            chk($sformatf("R5 R7 vec%0d fast ticks", v), n_tick, int'(VEC[v][2:1]));
            chk($sformatf("R5 R7 vec%0d active seen", v), (rise_at >= 0) ? 1 : 0, int'(VEC[v][0]));
        end

        // R4 R5 R6: exact timing of one accelerated cycle and the return to slow.
        do_reset(1'b1);
        run_until(10);
        link_up = 3'b110;
        run_until(110);
        chk("R4 flush latency", flush_at, 13);
        chk("R5 active rise", rise_at, 13);
        chk("R5 first fast tick", tick_at[0], 18);
        chk("R5 second fast tick", tick_at[1], 24);
        chk("R6 active fall", fall_at, 24);
        chk("R6 slow tick after burst", tick_at[2], 104);
        chk("R6 tick count", n_tick, 3);

        // R8: a second loss during the burst flushes but does not stretch it.
        do_reset(1'b1);
        run_until(10);
        link_up = 3'b110;
        run_until(14);
        link_up = 3'b100;
        run_until(110);
        chk("R8 second flush time", flush_at, 17);
        chk("R8 flush count", n_flush, 2);
        chk("R8 first tick", tick_at[0], 18);
        chk("R8 second tick", tick_at[1], 24);
        chk("R8 active fall", fall_at, 24);
        chk("R8 slow tick after", tick_at[2], 104);
        // R3: rising edges produce no flush.
        link_up = 3'b111;
        run_until(140);
        chk("R3 rising edge no flush", n_flush, 2);
        chk("R3 rising edge no active", int'(active), 0);

        // R2 R7: enable low, loss flushes, slow schedule unchanged.
        do_reset(1'b0);
        run_until(10);
        link_up = 3'b101;
        run_until(170);
        chk("R7 flush time", flush_at, 13);
        chk("R7 no active", rise_at, -1);
        chk("R2 R7 first slow tick", tick_at[0], 80);
        chk("R2 second slow tick", tick_at[1], 160);
        chk("R2 tick count", n_tick, 2);

        // R9: flush coincides with a due slow tick, enable low.
        do_reset(1'b0);
        run_until(77);
        link_up = 3'b011;
        run_until(170);
        chk("R9 flush at tick slot", flush_at, 80);
        chk("R9 next tick one interval later", tick_at[0], 160);
        chk("R9 tick count", n_tick, 1);

        // R9: same coincidence with enable high starts the burst instead.
        do_reset(1'b1);
        run_until(77);
        link_up = 3'b011;
        run_until(100);
        chk("R9 burst entry at flush", rise_at, 80);
        chk("R9 first burst tick", tick_at[0], 86);
        chk("R9 burst end", fall_at, 92);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule